// File: doc/BRIEF.md
# Bidirectional H-Bridge PWM Generator

This block produces the two half-bridge control signals for one H-bridge channel. A duty word in offset-binary form selects both the drive direction and the pulse width: the mid code means no drive, codes above it push the load forward through output A, and codes below it push it in reverse through output B. Pulses are timed by the block clock, one count per clock, within a period of fixed length.

The duty resolution can be set to 10, 11 or 12 bits. The period length follows the resolution, so finer settings give longer periods. A new duty word is picked up only when a period starts, so the outputs never show a clipped pulse. When a run enable is low, both outputs are forced low and the period counter is held at zero.

Top module: `hbridgePwm`

## Requirements
- R1: With resolution select `resSel` = 0, 1 or 2 the resolution N is 10, 11 or 12 bits; the value 3 selects 10 bits. A period lasts 2^(N-1) clock cycles. The first period begins in the first cycle after `runEn` is sampled high.
- R2: Only the low N bits of `dutyCode` are used; the upper bits are ignored. The mid code 2^(N-1) keeps both outputs low for the whole period.
- R3: A code c above the mid code (and not all ones) drives `driveA` high for the first c - 2^(N-1) cycles of each period, with `driveB` low. The two outputs are never high at the same time.
- R4: A code c below the mid code drives `driveB` high for the first 2^(N-1) - c cycles of each period, with `driveA` low. Code 0 keeps `driveB` high for the entire period.
- R5: The all-ones code (2^N - 1) holds `driveA` high for the entire period, with no low cycle.
- R6: While `runEn` is low, both outputs are low in that same cycle and the counter is held at zero. When `runEn` returns high, a fresh period starts with the current duty code.
- R7: A change of `dutyCode` takes effect only at the start of the next period. The period in progress keeps its width and direction.
- R8: A change of `resSel` while running ends the current period. The next cycle starts a new period at count zero, using the duty code decoded at the new resolution.
- R9: While `rstN` is low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PWM timebase clock, one count per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Run enable; low forces both outputs low |
| resSel | input | 2 | Resolution select: 0 = 10 bits, 1 = 11 bits, 2 = 12 bits, 3 = 10 bits |
| dutyCode | input | 12 | Offset-binary duty word; the low N bits are used |
| driveA | output | 1 | Half-bridge A control, high for forward drive |
| driveB | output | 1 | Half-bridge B control, high for reverse drive |

## Verification
The hardest cases to reach are changes that arrive in the middle of a period. A new duty code or a new resolution has to land at an arbitrary count, not at a boundary, to show that the period in progress is kept intact (R7) or is cut short cleanly (R8). The stimulus leaves the block running for a number of cycles that is not a multiple of the period length and then changes the input, so the change falls well inside a period. The same approach is used to drop and restore `runEn` mid-period. A behavioural model in the bench tracks the count and the latched duty, and the outputs are compared against it on every cycle.

// File: rtl/hbPwmPkg.sv
package hbPwmPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;  // drop latched drive (run low)
    logic load;   // latch a new duty word for the period starting next
  } hbStrobe_t;

  // Resolution in bits for a select code; code 3 falls back to the minimum
  function automatic int unsigned resBits(input logic [1:0] sel, input int unsigned minBits);
    return (sel == 2'd3) ? minBits : minBits + 32'(sel);
  endfunction

endpackage

// File: rtl/hbPwmCtrl.sv
module hbPwmCtrl
  import hbPwmPkg::*;
#(
  parameter int unsigned MIN_BITS = 10,
  parameter int unsigned CNT_W    = MIN_BITS + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic [1:0]       resSel,
  output hbStrobe_t        strobe,
  output logic [CNT_W-1:0] cnt
);

  logic             runQ;
  logic [1:0]       resQ;
  logic             resChange;
  logic [CNT_W-1:0] lastCnt;

  always_comb begin
    lastCnt   = CNT_W'((32'd1 << (resBits(resQ, MIN_BITS) - 1)) - 32'd1);
    resChange = (resSel != resQ);
  end

  always_comb begin
    strobe.clear = !runEn;
    strobe.load  = runEn && (!runQ || resChange || (cnt == lastCnt));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      runQ <= 1'b0;
      resQ <= '0;
    end else begin
      resQ <= resSel;
      runQ <= runEn;
      if (strobe.clear || strobe.load) cnt <= '0;
      else                             cnt <= cnt + 1'b1;
    end
  end

  // Counter stays inside the period of the active resolution
  assert_count_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= lastCnt);

  // Run low parks the counter at zero
  assert_stop_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (cnt == '0));

  // Resolution change while running restarts the period
  assert_res_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && (resSel != resQ)) |=> (cnt == '0));

endmodule

// File: rtl/hbPwmData.sv
module hbPwmData
  import hbPwmPkg::*;
#(
  parameter int unsigned MIN_BITS = 10,
  parameter int unsigned DUTY_W   = MIN_BITS + 2,
  parameter int unsigned CNT_W    = DUTY_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  hbStrobe_t         strobe,
  input  logic [1:0]        resSel,
  input  logic [DUTY_W-1:0] dutyCode,
  input  logic [CNT_W-1:0]  cnt,
  output logic              driveA,
  output logic              driveB
);

  localparam int unsigned MAG_W = CNT_W + 1;

  int unsigned       nBits;
  logic [DUTY_W-1:0] mask;
  logic [DUTY_W-1:0] code;
  logic [DUTY_W-1:0] mid;
  logic              fwdD;
  logic [MAG_W-1:0]  magD;
  logic              fwdQ;
  logic [MAG_W-1:0]  magQ;
  logic              active;

  // Offset-binary decode into direction and magnitude
  always_comb begin
    nBits = resBits(resSel, MIN_BITS);
    mask  = DUTY_W'((32'd1 << nBits) - 32'd1);
    mid   = DUTY_W'(32'd1 << (nBits - 1));
    code  = dutyCode & mask;
    if (code >= mid) begin
      fwdD = 1'b1;
      magD = (code == mask) ? MAG_W'(mid) : MAG_W'(code - mid);
    end else begin
      fwdD = 1'b0;
      magD = MAG_W'(mid - code);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fwdQ <= 1'b1;
      magQ <= '0;
    end else if (strobe.clear) begin
      fwdQ <= 1'b1;
      magQ <= '0;
    end else if (strobe.load) begin
      fwdQ <= fwdD;
      magQ <= magD;
    end
  end

  always_comb begin
    active = ({1'b0, cnt} < magQ);
    driveA = runEn &&  fwdQ && active;
    driveB = runEn && !fwdQ && active;
  end

  // Bridge legs are never driven together
  assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(driveA && driveB));

endmodule

// File: rtl/hbridgePwm.sv
module hbridgePwm
  import hbPwmPkg::*;
#(
  parameter int unsigned MIN_BITS = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  runEn,
  input  logic [1:0]            resSel,
  input  logic [MIN_BITS+1:0]   dutyCode,
  output logic                  driveA,
  output logic                  driveB
);

  localparam int unsigned DUTY_W = MIN_BITS + 2;
  localparam int unsigned CNT_W  = DUTY_W - 1;

  hbStrobe_t        strobe;
  logic [CNT_W-1:0] cnt;

  hbPwmCtrl #(.MIN_BITS(MIN_BITS), .CNT_W(CNT_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .runEn  (runEn),
    .resSel (resSel),
    .strobe (strobe),
    .cnt    (cnt)
  );

  hbPwmData #(.MIN_BITS(MIN_BITS), .DUTY_W(DUTY_W), .CNT_W(CNT_W)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .runEn    (runEn),
    .strobe   (strobe),
    .resSel   (resSel),
    .dutyCode (dutyCode),
    .cnt      (cnt),
    .driveA   (driveA),
    .driveB   (driveB)
  );

  // Duty words are taken only as a period begins
  assert_load_at_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (cnt == '0));

endmodule

// File: tb/hbridgePwm_tb.sv
module hbridgePwm_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic [1:0]  resSel = 2'd0;
  logic [11:0] dutyCode = 12'd0;
  logic        driveA, driveB;

  int checks = 0;
  int fails = 0;
  int highA = 0;
  int highB = 0;
  bit done = 0;
  string curReq = "R9";

  // reference model state
  int mCnt = 0, mMag = 0, mResQ = 0;
  bit mFwd = 1, mRunQ = 0;

  always #10 clk = ~clk;

  hbridgePwm u_dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .resSel(resSel),
    .dutyCode(dutyCode), .driveA(driveA), .driveB(driveB)
  );

  function automatic int bitsOf(input int s);
    return (s == 3) ? 10 : 10 + s;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mMag = 0; mFwd = 1; mRunQ = 0; mResQ = 0;
    end else begin
      int per, nb, c, s;
      s   = int'(resSel);
      per = 1 << (bitsOf(mResQ) - 1);
      if (!runEn) begin
        mCnt = 0; mMag = 0; mFwd = 1; mRunQ = 0;
      end else if (!mRunQ || s != mResQ || mCnt == per - 1) begin
        nb = bitsOf(s);
        c  = int'(dutyCode) % (1 << nb);
        if (c == (1 << nb) - 1)       begin mFwd = 1; mMag = 1 << (nb - 1); end
        else if (c >= (1 << (nb - 1))) begin mFwd = 1; mMag = c - (1 << (nb - 1)); end
        else                           begin mFwd = 0; mMag = (1 << (nb - 1)) - c; end
        mCnt = 0; mRunQ = 1;
      end else begin
        mCnt = mCnt + 1;
      end
      mResQ = s;
    end
  end

  task automatic compare();
    bit expA, expB;
    expA = runEn && rstN && mFwd && (mCnt < mMag);
    expB = runEn && rstN && !mFwd && (mCnt < mMag);
    checks++;
    if (driveA !== expA || driveB !== expB) begin
      fails++;
      $display("FAIL %s: driveA/driveB=%b%b expected %b%b", curReq, driveA, driveB, expA, expB);
    end
    if (driveA === 1'b1) highA++;
    if (driveB === 1'b1) highB++;
  endtask

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n, input bit r, input int s, input int d);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      runEn = r; resSel = s[1:0]; dutyCode = d[11:0];
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    // R9: reset holds outputs low even with run requested
    curReq = "R9";
    step(1, 1, 0, 700);
    step(3, 1, 0, 700);
    @(negedge clk);
    rstN = 1'b1; runEn = 1'b0;

    // R2: mid code, also with upper bits set (ignored at 10 bits)
    curReq = "R2";
    step(600, 1, 0, 512);
    highA = 0; highB = 0;
    step(600, 1, 0, 12'hE00);
    checkEq("R2", highA + highB, 0);

    // R3: forward, width 100 in a 512-cycle period
    curReq = "R3";
    step(513, 1, 0, 612);
    highA = 0; highB = 0;
    step(512, 1, 0, 612);
    checkEq("R3", highA, 100);
    checkEq("R3", highB, 0);

    // R4: reverse codes, code 0 = full reverse
    curReq = "R4";
    step(700, 1, 0, 475);
    step(513, 1, 0, 0);
    highA = 0; highB = 0;
    step(512, 1, 0, 0);
    checkEq("R4", highB, 512);

    // R5: all-ones code holds A high
    curReq = "R5";
    step(513, 1, 0, 1023);
    highA = 0; highB = 0;
    step(512, 1, 0, 1023);
    checkEq("R5", highA, 512);

    // R7: duty change lands mid-period
    curReq = "R7";
    step(200, 1, 0, 700);
    step(1300, 1, 0, 300);
    step(777, 1, 0, 900);

    // R1: 11-bit, 12-bit and fallback select
    curReq = "R1";
    step(2200, 1, 1, 1524);
    step(4200, 1, 2, 1048);
    step(1100, 1, 3, 517);

    // R8: resolution change mid-period
    curReq = "R8";
    step(300, 1, 0, 1900);
    step(2500, 1, 2, 1900);
    step(333, 1, 1, 1900);

    // R6: run dropped mid-period, then restored
    curReq = "R6";
    step(150, 1, 0, 800);
    step(5, 0, 0, 800);
    step(700, 1, 0, 800);
    step(3, 0, 0, 100);
    step(600, 1, 0, 100);

    finishRun();
  end

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

endmodule